// File: doc/BRIEF.md
# Phase-Offset Numerically Controlled Oscillator

This block is a digital sine source that runs on the system clock. A 32-bit phase accumulator adds an active tuning word on every clock edge and wraps at full scale. The upper bits of the accumulator take a 5-bit phase offset, added in 11.25° steps, and the sum is cut to a 14-bit phase index. A quarter-wave cosine table, mirrored into all four quadrants, turns that index into a registered 10-bit unsigned amplitude sample for an external converter. The output frequency is tuning_word × f_clk / 2^32.

New tuning and offset values are first written into a holding register. They reach the active registers only when an update request arrives. The request may be asynchronous, so it is synchronized and edge-detected. A frequency change never touches the accumulator, so the waveform stays phase-continuous. A synchronous reset forces the output to positive full scale at 0 Hz. A power-down input freezes the phase and parks the output at mid-scale.

Top module: `phase_nco`

## Requirements
- R1: A clock edge with `rst` high sets `amp` to 1023 after that edge and clears the accumulator, the active tuning word and the active offset. With no later update, `amp` then stays at 1023.
- R2: An edge with `stage_we` high copies `stage_ftw` and `stage_ofs` into the holding register, with no effect on `amp` until an update. Reset leaves the holding register unchanged, so an update after reset restores the last staged values.
- R3: Let edge N be the first edge that sees `upd_req` high after it was low (held high for at least two edges). The holding register moves into the active registers at edge N+2, and every other edge leaves them unchanged.
- R4: On each edge with `pwr_down` low, the accumulator adds the active tuning word modulo 2^32.
- R5: Loading a new tuning word leaves the accumulator value unchanged. On the loading edge the old word is still added, and the new word is used from the next edge on.
- R6: The phase index is (accumulator bits [31:18] + offset × 512) mod 16384, so one offset step is 1/32 of a cycle.
- R7: `amp` is unsigned and lies within 1 LSB of 511.5 + 511·cos(2π(p+0.5)/16384) for phase index p. Indices whose bits [13:12] are 00 or 11 give `amp` ≥ 512, and indices whose bits are 01 or 10 give `amp` ≤ 511.
- R8: Phase index 0 gives 1023, 4096 gives 511, 8192 gives 0 and 12288 gives 512.
- R9: An edge with `pwr_down` high sets `amp` to 512 and holds the accumulator. When `pwr_down` falls, accumulation resumes from the held phase.
- R10: `amp` after an edge reflects the accumulator and the active offset as they were just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_down | input | 1 | Freezes the phase and parks the output at mid-scale |
| stage_we | input | 1 | Writes the holding register |
| stage_ftw | input | 32 | Tuning word to stage |
| stage_ofs | input | 5 | Phase offset to stage, 11.25° per step |
| upd_req | input | 1 | Update request, may be asynchronous |
| amp | output | 10 | Unsigned amplitude sample |

## Verification
The amplitude is due one edge after the accumulator state it reflects. Staged settings become active two edges after the first edge that sees the request, so they show up in `amp` at the fourth edge counted from that first one. The bench keeps its own cycle model of the holding register, the active registers and the accumulator, and advances it once per clock edge. It compares `amp` at the falling edge that follows, so every expectation lines up with the exact edge on which the design must change. The update latency is also checked directly: `amp` keeps its old value after edge N+2 and takes the new value after edge N+3. A full 16384-step sweep, a mid-run frequency change, an offset wrap, a power-down window and a reset while running all go through the same model.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam longint ONE_Q30 = 64'sd1073741824;
  localparam longint PI_Q30  = 64'sd3373259426;

  // Rounded magnitude of cos over the first quarter wave, sampled at
  // bin centres: round(peak * cos(pi*(2*idx+1)/2^(qbits+2))), with
  // peak = 2^magw - 1. The cosine comes from a fixed-point Taylor series.
  function automatic int quarter_cos_mag(input int idx, input int qbits, input int magw);
    longint x;
    longint term;
    longint sum;
    longint peak;
    longint res;
    x    = (PI_Q30 * longint'(2 * idx + 1)) >>> (qbits + 2);
    term = ONE_Q30;
    sum  = ONE_Q30;
    for (int k = 1; k <= 8; k++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'((2 * k - 1) * (2 * k));
      sum  = sum + term;
    end
    peak = (longint'(1) <<< magw) - 1;
    res  = (peak * sum + (ONE_Q30 >>> 1)) >>> 30;
    if (res < 0) res = 0;
    if (res > peak) res = peak;
    return int'(res);
  endfunction

  // Phase index: top bits of the accumulator plus the offset at the index MSBs.
  function automatic logic [31:0] offset_phase(input logic [31:0] acc_top,
                                               input logic [31:0] ofs,
                                               input int ph_w, input int ofs_w);
    logic [31:0] mask;
    mask = (32'd1 << ph_w) - 32'd1;
    return (acc_top + (ofs << (ph_w - ofs_w))) & mask;
  endfunction

endpackage

// File: rtl/nco_update_sync.sv
module nco_update_sync (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic load_pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= req_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign load_pulse = sync_q & ~prev_q;

  // R3: a load event lasts a single cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);
endmodule

// File: rtl/nco_settings.sv
module nco_settings #(
  parameter int FTW_W = 32,
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [FTW_W-1:0] wr_ftw,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic             load,
  output logic [FTW_W-1:0] ftw_act,
  output logic [OFS_W-1:0] ofs_act
);
  logic [FTW_W-1:0] hold_ftw;
  logic [OFS_W-1:0] hold_ofs;

  // Holding register: deliberately outside reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      hold_ftw <= wr_ftw;
      hold_ofs <= wr_ofs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act <= '0;
      ofs_act <= '0;
    end else if (load) begin
      ftw_act <= hold_ftw;
      ofs_act <= hold_ofs;
    end
  end

  // R3: active settings move only on a load event
  p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ftw_act) && $stable(ofs_act)));
  // R2: a load copies the staged values
  p_load_copies_r2: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_en) |=> (ftw_act == $past(hold_ftw)));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 5,
  parameter int PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFS_W-1:0] ofs,
  output logic [ACC_W-1:0] acc,
  output logic [PH_W-1:0]  phase_idx
);
  logic [ACC_W-1:0] acc_next;
  logic [31:0]      ph_full;

  assign acc_next = acc + ftw;

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (!hold) acc <= acc_next;
  end

  assign ph_full   = nco_pkg::offset_phase(32'(acc[ACC_W-1 -: PH_W]), 32'(ofs), PH_W, OFS_W);
  assign phase_idx = ph_full[PH_W-1:0];

  // R9: the accumulator is frozen in power-down
  p_pd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (acc == $past(acc)));
endmodule

// File: rtl/nco_amp_map.sv
module nco_amp_map #(
  parameter int PH_W  = 14,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             park,
  input  logic [PH_W-1:0]  phase_idx,
  output logic [AMP_W-1:0] amp
);
  localparam int QBITS = PH_W - 2;
  localparam int QN    = 1 << QBITS;
  localparam int MAG_W = AMP_W - 1;
  localparam logic [AMP_W-1:0] AMP_MID = AMP_W'(1) << (AMP_W - 1);

  logic [MAG_W-1:0] rom [QN];

  for (genvar g = 0; g < QN; g++) begin : g_rom
    localparam logic [MAG_W-1:0] MAGV = MAG_W'(nco_pkg::quarter_cos_mag(g, QBITS, MAG_W));
    assign rom[g] = MAGV;
  end

  logic [1:0]       quad;
  logic [QBITS-1:0] fold_idx;
  logic [MAG_W-1:0] mag;
  logic             pos_half;
  logic [AMP_W-1:0] sample;

  assign quad     = phase_idx[PH_W-1 -: 2];
  assign fold_idx = quad[0] ? ~phase_idx[QBITS-1:0] : phase_idx[QBITS-1:0];
  assign mag      = rom[fold_idx];
  assign pos_half = (quad[1] == quad[0]);
  assign sample   = pos_half ? {1'b1, mag} : {1'b0, ~mag};

  always_ff @(posedge clk) begin
    if (rst)       amp <= '1;
    else if (park) amp <= AMP_MID;
    else           amp <= sample;
  end

  // R7: quadrant sets the half of the output range
  p_upper_half_r7: assert property (@(posedge clk) disable iff (rst)
    (!park && pos_half) |=> amp[AMP_W-1]);
  p_lower_half_r7: assert property (@(posedge clk) disable iff (rst)
    (!park && !pos_half) |=> !amp[AMP_W-1]);
  // R9: power-down parks the output at mid-scale
  p_pd_mid_r9: assert property (@(posedge clk) disable iff (rst)
    park |=> (amp == AMP_MID));
  // R1: reset forces positive full scale
  p_reset_full_r1: assert property (@(posedge clk)
    rst |=> (amp == '1));
endmodule

// File: rtl/phase_nco.sv
module phase_nco #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 5,
  parameter int PH_W  = 14,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_down,
  input  logic             stage_we,
  input  logic [ACC_W-1:0] stage_ftw,
  input  logic [OFS_W-1:0] stage_ofs,
  input  logic             upd_req,
  output logic [AMP_W-1:0] amp
);
  logic             upd_pulse;
  logic [ACC_W-1:0] ftw_act;
  logic [OFS_W-1:0] ofs_act;
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  phase_idx;

  nco_update_sync u_sync (
    .clk(clk), .rst(rst), .req_async(upd_req), .load_pulse(upd_pulse)
  );

  nco_settings #(.FTW_W(ACC_W), .OFS_W(OFS_W)) u_set (
    .clk(clk), .rst(rst), .wr_en(stage_we), .wr_ftw(stage_ftw), .wr_ofs(stage_ofs),
    .load(upd_pulse), .ftw_act(ftw_act), .ofs_act(ofs_act)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .hold(pwr_down), .ftw(ftw_act), .ofs(ofs_act),
    .acc(acc), .phase_idx(phase_idx)
  );

  nco_amp_map #(.PH_W(PH_W), .AMP_W(AMP_W)) u_map (
    .clk(clk), .rst(rst), .park(pwr_down), .phase_idx(phase_idx), .amp(amp)
  );

  // R5: a settings load does not disturb the running phase
  p_load_keeps_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse && !pwr_down) |=> (acc == $past(acc) + $past(ftw_act)));
  // R1: reset leaves the core at 0 Hz
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && ftw_act == '0 && ofs_act == '0));
endmodule

// File: tb/sim_phase_nco.sv
`timescale 1ns/1ps
module sim_phase_nco;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        b_rst = 1'b1, b_pd = 1'b0, b_we = 1'b0, b_upd = 1'b0;
  logic [31:0] b_ftw = '0;
  logic [4:0]  b_ofs = '0;
  logic [9:0]  amp;

  phase_nco u0 (
    .clk(clk), .rst(b_rst), .pwr_down(b_pd), .stage_we(b_we),
    .stage_ftw(b_ftw), .stage_ofs(b_ofs), .upd_req(b_upd), .amp(amp)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Bench model
  logic [31:0] m_acc = '0, m_ftw = '0, h_ftw = '0;
  logic [4:0]  m_ofs = '0, h_ofs = '0;
  int          pend = 0;
  bit          upd_prev = 1'b0;

  task automatic fail_line(string tag, int act, real expv);
    errs++;
    $display("FAIL %s actual=%0d expected=%f", tag, act, expv);
  endtask

  task automatic exact(string tag, int val);
    checks++;
    if (int'(amp) != val) fail_line(tag, int'(amp), real'(val));
  endtask

  // Advance one edge; model updates there; compare at the next falling edge.
  task automatic cyc();
    bit   ex;
    int   eval_v;
    int   eidx;
    real  v;
    real  d;
    ex = 1'b0; eval_v = 0; eidx = 0;
    if (b_rst)     begin ex = 1'b1; eval_v = 1023; end
    else if (b_pd) begin ex = 1'b1; eval_v = 512; end
    else eidx = (int'(m_acc[31:18]) + int'(m_ofs) * 512) % 16384;
    @(posedge clk);
    if (b_rst) begin
      m_acc = '0; m_ftw = '0; m_ofs = '0; pend = 0;
    end else begin
      if (!b_pd) m_acc = m_acc + m_ftw;
      if (b_upd && !upd_prev) pend = 2;
      else if (pend > 0) begin
        pend--;
        if (pend == 0) begin m_ftw = h_ftw; m_ofs = h_ofs; end
      end
    end
    upd_prev = b_rst ? 1'b0 : b_upd;
    if (b_we) begin h_ftw = b_ftw; h_ofs = b_ofs; end
    @(negedge clk);
    checks++;
    if (ex) begin
      if (int'(amp) != eval_v) fail_line(cur_req, int'(amp), real'(eval_v));
    end else begin
      v = 511.5 + 511.0 * $cos(2.0 * 3.14159265358979 * (real'(eidx) + 0.5) / 16384.0);
      d = real'(amp) - v;
      if (d > 1.0 || d < -1.0) fail_line(cur_req, int'(amp), v);
      else if (((eidx >> 12) == 0 || (eidx >> 12) == 3) != (amp >= 10'd512))
        fail_line({cur_req, " R7 half"}, int'(amp), v);
    end
  endtask

  task automatic stage(logic [31:0] f, logic [4:0] o);
    b_ftw = f; b_ofs = o; b_we = 1'b1;
    cyc();
    b_we = 1'b0;
  endtask

  // Request held for two edges; returns after edge N+2 (load edge).
  task automatic update();
    b_upd = 1'b1; cyc(); cyc();
    b_upd = 1'b0; cyc();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1"; run(3);
    exact("R1 reset full scale", 1023);
    b_rst = 1'b0;
    run(5);
    exact("R1 idle at 0 Hz", 1023);

    // R2: staging alone changes nothing
    cur_req = "R2";
    stage(32'd0, 5'd16);
    run(4);
    exact("R2 staged not applied", 1023);

    // R3 latency and R8 point 8192
    cur_req = "R3";
    b_upd = 1'b1; cyc();          // edge N
    cyc();                         // edge N+1
    b_upd = 1'b0; cyc();           // edge N+2: load
    exact("R3 unchanged after load edge", 1023);
    cyc();                         // edge N+3
    exact("R8 phase 8192", 0);

    cur_req = "R6";
    stage(32'd0, 5'd8);  update(); cyc(); exact("R8 phase 4096", 511);
    stage(32'd0, 5'd24); update(); cyc(); exact("R8 phase 12288", 512);
    stage(32'd0, 5'd0);  update(); cyc(); exact("R8 phase 0", 1023);

    // R4/R7/R10: full sweep, one index per clock, past the wrap
    cur_req = "R7";
    stage(32'h0004_0000, 5'd0); update();
    run(16384 + 40);

    // R5: frequency change mid-run
    cur_req = "R5";
    stage(32'h0123_4567, 5'd0); update();
    run(2000);

    // R6: offset wrap with a near-full-scale tuning word
    cur_req = "R6";
    stage(32'hFFFF_0000, 5'd31); update();
    run(1000);
    stage(32'h0A3D_70A4, 5'd5); update();
    run(600);

    // R9: power-down and resume
    cur_req = "R9";
    b_pd = 1'b1; run(50);
    exact("R9 mid-scale", 512);
    b_pd = 1'b0; run(300);

    // R1 reset while running, then R2 holding register survives reset
    cur_req = "R1";
    b_rst = 1'b1; cyc();
    exact("R1 reset mid-run", 1023);
    b_rst = 1'b0; run(10);
    exact("R1 stays full scale", 1023);
    cur_req = "R2";
    update();
    run(500);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule